// File: doc/BRIEF.md
# Program Status Register with Saved Copies

This block holds the processor's current status word and five saved status words. The current word packs four condition flags, two interrupt masks, an instruction-state bit and a 5-bit operating mode. Each saved word belongs to one exception mode, and the same read and write port reaches whichever copy belongs to the mode that is active at that moment. The block rejects requests that are not legal. A current-word write that names an unknown mode is refused. Any access to a saved word from a mode that has no saved copy is also refused. A refused request leaves the state unchanged and raises a one-cycle error pulse.

The current word can always be read, combinationally. The saved word of the active mode also appears combinationally on its own read bus. Writes take effect at the next rising clock edge. A write to the current word from the unprivileged mode changes only the condition flags. This lets flag-setting code run there without any way to raise its own privilege.

Top module: `psr_bank`

## Requirements
- R1: After reset the current word reads 0x000000D3: mode 0x13, both interrupt masks (bits 7 and 6) set, state bit 5 clear, flags clear. All five saved words read zero.
- R2: The current word places the flags at bits 31 (negative), 30 (zero), 29 (carry) and 28 (overflow), the interrupt mask at bit 7, the fast-interrupt mask at bit 6, the state bit at bit 5 and the mode at bits 4:0. All other bits read zero. In any mode other than user, a write with a legal mode updates every field at the next edge.
- R3: The legal modes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. A current-word write from a mode other than user that carries any other mode value leaves the word unchanged and raises err in the next cycle.
- R4: A current-word write in user mode (0x10) updates only bits 31:28. The mode field of the written value is ignored, and such a write never raises err.
- R5: Saved-word reads and writes select one of five independent copies by the current mode: 0x11, 0x12, 0x13, 0x17 or 0x1B. A saved write stores bits 31:28 and 7:0 of the written value, and the other bits read zero.
- R6: In user (0x10) or system (0x1F) mode, a saved-word read or write raises err in the next cycle. The write changes no copy, and sav_rdata reads zero.
- R7: err is high for exactly one cycle after each cycle that holds a refused request, and low after any cycle without one.
- R8: When the current word and the saved word are written in the same cycle, the saved write goes to the copy of the mode that was active before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_we | input | 1 | Write strobe for the current word |
| cur_wdata | input | 32 | Value to write into the current word |
| cur_rdata | output | 32 | Current word |
| sav_we | input | 1 | Write strobe for the saved word of the current mode |
| sav_re | input | 1 | Read strobe for the saved word; used only to detect a refused read |
| sav_wdata | input | 32 | Value to write into the saved word |
| sav_rdata | output | 32 | Saved word of the current mode; zero in user and system mode |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench aims at the mode boundaries. It writes unknown mode codes next to the legal ones (0x14, 0x15, 0x16, 0x18). A design that decoded the mode loosely would accept such a code and leave the word in an undefined mode. Saved-word traffic is spread across all five copies while the mode switches. An indexing error would then show up as one copy's data appearing under another mode, or as a user- or system-mode access that clobbers a copy. User-mode writes with all bits set expose a design that lets user code change its masks or its mode. Simultaneous current and saved writes expose a design that selects the saved copy by the new mode.

// File: rtl/psr_bank.sv
module psr_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cur_we,
  input  logic [31:0] cur_wdata,
  output logic [31:0] cur_rdata,
  input  logic        sav_we,
  input  logic        sav_re,
  input  logic [31:0] sav_wdata,
  output logic [31:0] sav_rdata,
  output logic        err
);
  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12,
                         M_SVC = 5'h13, M_ABT = 5'h17, M_UND = 5'h1B,
                         M_SYS = 5'h1F;
  localparam logic [31:0] KEEP = 32'hF000_00FF;

  logic [3:0]  flags;
  logic        irq_mask, fiq_mask, state;
  logic [4:0]  mode;
  logic [31:0] saved [5];
  logic        err_q;

  function automatic logic legal(input logic [4:0] m);
    return m inside {M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
  endfunction

  logic       user, sav_ok, cur_bad, sav_bad;
  logic [2:0] idx;

  always_comb begin
    sav_ok = 1'b1;
    unique case (mode)
      M_FIQ:   idx = 3'd0;
      M_IRQ:   idx = 3'd1;
      M_SVC:   idx = 3'd2;
      M_ABT:   idx = 3'd3;
      M_UND:   idx = 3'd4;
      default: begin idx = 3'd0; sav_ok = 1'b0; end
    endcase
  end

  assign user      = (mode == M_USR);
  assign cur_bad   = cur_we && !user && !legal(cur_wdata[4:0]);
  assign sav_bad   = (sav_we || sav_re) && !sav_ok;
  assign cur_rdata = {flags, 20'd0, irq_mask, fiq_mask, state, mode};
  assign sav_rdata = sav_ok ? saved[idx] : 32'd0;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= 4'd0;
      irq_mask <= 1'b1;
      fiq_mask <= 1'b1;
      state    <= 1'b0;
      mode     <= M_SVC;
      err_q    <= 1'b0;
      for (int i = 0; i < 5; i++) saved[i] <= 32'd0;
    end else begin
      err_q <= cur_bad || sav_bad;
      if (cur_we && !cur_bad) begin
        flags <= cur_wdata[31:28];
        if (!user) begin
          irq_mask <= cur_wdata[7];
          fiq_mask <= cur_wdata[6];
          state    <= cur_wdata[5];
          mode     <= cur_wdata[4:0];
        end
      end
      if (sav_we && sav_ok) saved[idx] <= sav_wdata & KEEP;
    end
  end
endmodule

module psr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cur_we,
  input logic [31:0] cur_wdata,
  input logic [31:0] cur_rdata,
  input logic        sav_we,
  input logic        sav_re,
  input logic [31:0] sav_rdata,
  input logic        err
);
  logic usr_or_sys, known;
  assign usr_or_sys = (cur_rdata[4:0] == 5'h10) || (cur_rdata[4:0] == 5'h1F);
  assign known = cur_wdata[4:0] inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_rdata[27:8] == 20'd0);
  // R3
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_we && cur_rdata[4:0] != 5'h10 && !known) |=> ($stable(cur_rdata) && err));
  // R4
  user_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_we && cur_rdata[4:0] == 5'h10) |=> (cur_rdata[27:0] == $past(cur_rdata[27:0])));
  // R6
  sav_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usr_or_sys |-> sav_rdata == 32'd0);
  // R6
  sav_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sav_we || sav_re) && usr_or_sys) |=> err);
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_we && !sav_we && !sav_re) |=> !err);
endmodule

bind psr_bank psr_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_wdata(cur_wdata),
  .cur_rdata(cur_rdata), .sav_we(sav_we), .sav_re(sav_re),
  .sav_rdata(sav_rdata), .err(err)
);

// File: tb/psr_bank_bench.sv
module psr_bank_bench;
  logic clk = 0, rst_n = 0;
  logic cur_we = 0, sav_we = 0, sav_re = 0;
  logic [31:0] cur_wdata = 0, sav_wdata = 0;
  logic [31:0] cur_rdata, sav_rdata;
  logic err;

  psr_bank u_psr_bank (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_cur;
  logic [31:0] m_sav [5];
  logic m_err;

  function automatic bit legal(input logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  endfunction

  function automatic int sidx(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cur_we = 0; sav_we = 0; sav_re = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_cur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sav[i] = 0;
    chk(cur_rdata, 32'h0000_00D3, "R1 reset word");
    chk({31'd0, err}, 32'd0, "R1 reset err");
    chk(sav_rdata, 32'd0, "R1 reset saved");
  endtask

  task automatic step(input bit cw, input logic [31:0] cd, input bit sw,
                      input bit sr, input logic [31:0] sd, input string tag);
    int k;
    bit user, badc, bads;
    @(negedge clk);
    cur_we = cw; cur_wdata = cd; sav_we = sw; sav_re = sr; sav_wdata = sd;
    #1;
    k = sidx(m_cur[4:0]);
    chk(sav_rdata, (k < 0) ? 32'd0 : m_sav[k], (k < 0) ? "R6 saved read" : "R5 saved read");
    user = (m_cur[4:0] == 5'h10);
    badc = cw && !user && !legal(cd[4:0]);
    bads = (sw || sr) && (k < 0);
    if (sw && k >= 0) m_sav[k] = sd & 32'hF000_00FF;
    if (cw && !badc)
      m_cur = user ? {cd[31:28], m_cur[27:0]} : (cd & 32'hF000_00FF);
    m_err = badc || bads;
    @(posedge clk);
    #1;
    cur_we = 0; sav_we = 0; sav_re = 0;
    chk(cur_rdata, m_cur, tag);
    chk({31'd0, err}, {31'd0, m_err}, m_err ? (badc ? "R3 err" : "R6 err") : "R7 err");
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R2 full update in supervisor mode
    step(1, 32'hA000_0051, 0, 0, 0, "R2 legal write");
    chk(cur_rdata, 32'hA000_0051, "R2 layout");
    // R3 unknown modes refused
    step(1, 32'hF000_0015, 0, 0, 0, "R3 bad mode 15");
    step(1, 32'h5000_0018, 0, 0, 0, "R3 bad mode 18");
    // R5 per-mode copies
    step(0, 0, 1, 0, 32'h1234_5678, "R5 fiq write");
    step(1, 32'h0000_0012, 0, 0, 0, "R5 to irq");
    step(0, 0, 1, 1, 32'hFFFF_FFFF, "R5 irq write");
    step(1, 32'h0000_0011, 0, 0, 0, "R5 back fiq");
    chk(sav_rdata, 32'h1000_0078, "R5 fiq copy kept");
    // R8 simultaneous writes use old mode (fiq)
    step(1, 32'h0000_001B, 1, 0, 32'h8000_0001, "R8 both writes");
    step(1, 32'h0000_0011, 0, 0, 0, "R8 back fiq");
    chk(sav_rdata, 32'h8000_0001, "R8 went to fiq copy");
    // R6 system mode
    step(1, 32'h0000_001F, 0, 0, 0, "R6 to system");
    step(0, 0, 1, 1, 32'h5555_5555, "R6 system access");
    // R4 user mode
    step(1, 32'h0000_0010, 0, 0, 0, "R4 to user");
    step(1, 32'hFFFF_FFF5, 0, 0, 0, "R4 user write");
    chk(cur_rdata, 32'hF000_0010, "R4 only flags");
    step(0, 0, 0, 1, 0, "R6 user read");
    step(0, 0, 0, 0, 0, "R7 idle");
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] cd, sd;
      logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
      if (n % 50 == 49) do_reset();
      cd = $urandom;
      if ($urandom_range(0, 3) != 0) cd[4:0] = modes[$urandom_range(0, 6)];
      sd = $urandom;
      step($urandom_range(0, 2) == 0, cd, $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0, sd,
           (m_cur[4:0] == 5'h10) ? "R4 random" : "R2 R3 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule